// File: doc/BRIEF.md
# Peripheral Reset Line Bank

This block holds a bank of active-low reset lines, one line for each peripheral in a group. Software never rewrites the whole bank. It writes a mask to one of two registers. Ones in the mask written to the hold register pull the matching lines low, which keeps those peripherals in reset. Ones in the mask written to the free register drive the matching lines high. Zero bits in either mask leave their lines as they were. A third, read-only register returns the level that each line carries at that moment.

Access is through a plain synchronous register bus: a byte address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the read strobe. After a system reset every line starts low. A peripheral stays in reset until software writes a one for it to the free register. A full reset pulse for a peripheral is a hold write followed by a free write to the same bit. The block accepts these on back-to-back cycles.

Top module: `rst_line_bank`

## Requirements
- R1: While the system reset `rst_n` is low, and after it is released, every bit of `line_n` is 0. Read data is 0.
- R2: A write of mask M to offset 0x01C (hold) drives `line_n` low for every bit set in M, on the clock edge that accepts the write.
- R3: A write of mask M to offset 0x018 (free) drives `line_n` high for every bit set in M, on the clock edge that accepts the write.
- R4: Bits that are 0 in a hold or free mask leave the matching lines unchanged.
- R5: A read of offset 0x020 (level) returns the current `line_n` value in `rd_data`, one cycle after `rd_en`.
- R6: A write to offset 0x020, or to any unmapped offset, leaves `line_n` unchanged.
- R7: A read of 0x018, 0x01C or any unmapped offset returns 0 in `rd_data` one cycle later.
- R8: A hold write followed on the next cycle by a free write of the same bits leaves those lines high. Each line is low for exactly one cycle in between.
- R9: When no read is requested, `rd_data` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, synchronous |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | LINES | Write mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | LINES | Read data, one cycle after rd_en |
| line_n | output | LINES | Active-low reset lines |

## Verification
A corrupted line register shows up directly on `line_n` in the cycle after the bad write. It also shows up in the level readback one cycle after the next read. A wrong decode, such as hold and free being swapped or an unmapped offset being treated as mapped, flips line levels that a reference model tracks bit by bit. The mismatch therefore appears within one cycle of the offending write. A read mux that leaks stale data is caught on the first read of a write-only or unmapped offset that follows a level read.

// File: rtl/rst_line_bank.sv
module rst_line_bank #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_FREE  = 'h018,
  parameter logic [ADDR_W-1:0] OFS_HOLD  = 'h01C,
  parameter logic [ADDR_W-1:0] OFS_LEVEL = 'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LINES-1:0]  wr_data,
  input  logic              rd_en,
  output logic [LINES-1:0]  rd_data,
  output logic [LINES-1:0]  line_n
);
  logic [LINES-1:0] lines_q;
  logic [LINES-1:0] hold_m, free_m;

  assign hold_m = (wr_en && addr == OFS_HOLD) ? wr_data : '0;
  assign free_m = (wr_en && addr == OFS_FREE) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= (lines_q & ~hold_m) | free_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        rd_data <= '0;
    else if (rd_en && addr == OFS_LEVEL) rd_data <= lines_q;
    else                               rd_data <= '0;
  end

  assign line_n = lines_q;
endmodule

// File: rtl/rst_line_bank_chk.sv
module rst_line_bank_chk #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [LINES-1:0]  wr_data,
  input logic              rd_en,
  input logic [LINES-1:0]  rd_data,
  input logic [LINES-1:0]  line_n
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> line_n == '0);
  a_r2_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h01C) |=> ((line_n & $past(wr_data)) == '0));
  a_r3_free_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h018) |=> ((line_n & $past(wr_data)) == $past(wr_data)));
  a_r6_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !(wr_en && (addr == 12'h018 || addr == 12'h01C))) |=> $stable(line_n));
  a_r5_level_read: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rd_en && addr == 12'h020) |=> rd_data == $past(line_n));
  a_r7_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == 12'h020) |=> rd_data == '0);
endmodule

bind rst_line_bank rst_line_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_rst_line_bank.sv
module test_rst_line_bank;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data, line_n, model;
  int checks = 0, fails = 0;

  rst_line_bank i_rst_line_bank (.*);
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_lines(logic [31:0] cur, logic [11:0] a, logic [31:0] m);
    if (a == 12'h01C) return cur & ~m;
    if (a == 12'h018) return cur | m;
    return cur;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
    model = next_lines(model, a, d);
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(posedge clk); #1;
    rd_en = 0; d = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(1234));
    model = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", line_n, '0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset", line_n, '0);
    check("R1 rd_data", rd_data, '0);
    wr(12'h018, 32'h0000_00F0);
    check("R3 free", line_n, 32'h0000_00F0);
    wr(12'h01C, 32'h0000_0030);
    check("R2 hold", line_n, 32'h0000_00C0);
    wr(12'h018, 32'h0000_0000);
    check("R4 zero mask", line_n, 32'h0000_00C0);
    rd(12'h020, d);
    check("R5 level read", d, 32'h0000_00C0);
    rd(12'h018, d);
    check("R7 free read", d, '0);
    rd(12'h01C, d);
    check("R7 hold read", d, '0);
    rd(12'h100, d);
    check("R7 unmapped read", d, '0);
    check("R9 idle", rd_data, '0);
    wr(12'h020, 32'hFFFF_FFFF);
    check("R6 level write", line_n, 32'h0000_00C0);
    wr(12'h024, 32'hFFFF_FFFF);
    check("R6 unmapped write", line_n, 32'h0000_00C0);
    wr(12'h018, 32'hFFFF_FFFF);
    addr = 12'h01C; wr_data = 32'h8000_0001; wr_en = 1;
    @(posedge clk); #1;
    check("R8 pulse low", line_n, 32'h7FFF_FFFE);
    addr = 12'h018;
    @(posedge clk); #1;
    wr_en = 0;
    check("R8 pulse end", line_n, 32'hFFFF_FFFF);
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [31:0] m;
      int s;
      s = $urandom_range(0, 4);
      a = (s == 0) ? 12'h018 : (s == 1) ? 12'h01C : (s == 2) ? 12'h020 :
          (s == 3) ? 12'h014 : 12'h028;
      m = $urandom();
      if ($urandom_range(0, 1) == 0) m = m & $urandom();
      if ($urandom_range(0, 2) == 0) begin
        rd(a, d);
        check("R5 R7 random read", d, (a == 12'h020) ? model : 32'h0);
      end else begin
        wr(a, m);
        check("R2 R3 R4 R6 random write", line_n, model);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule